// File: doc/BRIEF.md
# Multiplier-Free FIR Filter Using Bit-Slice Lookup

This block is a fixed-coefficient finite impulse response filter. It computes the sum of products between the most recent input samples and a set of constant weights without any multiplier. The taps are split into small groups. Each group owns a constant table with one entry for every subset of its weights, and each entry holds the sum of the weights in that subset. For every bit position of the stored samples, the table is indexed by that bit taken from each sample in the group. The results for all bit positions are weighted by powers of two and summed in the same cycle. The group results are then added to give the output.

The weights are given as one packed parameter and the tables are computed from it at elaboration. Samples are two's-complement integers that arrive with a valid strobe. Each accepted sample produces exactly one full-precision result on the output after a fixed three-cycle latency. A new sample can be accepted on every clock. The output register holds the last result until the next one arrives.

Top module: `dafir_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid_o` is 0 and `out_data_o` is 0. All stored samples start at zero.
- R2: Each clock edge that samples `in_valid_i` high produces exactly one `out_valid_o` pulse, and that pulse appears three clock edges later. `out_valid_o` is never high otherwise.
- R3: The result for input sample n is y(n) = sum over k of c(k)·x(n−k), with k from 0 to NUM_TAPS−1. Tap 0 is the newest sample. c(k) is the signed COEF_W-bit field at bit offset k·COEF_W of `COEFS`. The result is a two's-complement value DATA_W+COEF_W+clog2(NUM_TAPS) bits wide.
- R4: Cycles with `in_valid_i` low do not shift the sample history, and the value on `in_data_i` during those cycles does not affect any later result.
- R5: `out_data_o` keeps its last value in every cycle where `out_valid_o` is low.
- R6: The output never overflows, including when every sample is the most negative or most positive input value. Its magnitude never exceeds sum|c(k)|·2^(DATA_W−1).
- R7: When NUM_TAPS is not a multiple of GROUP_TAPS, the taps in the last, partly filled group still contribute their weights. An impulse input therefore returns every weight in tap order.
- R8: The input MSB is the sign bit. Its bit-slice lookup is subtracted with weight 2^(DATA_W−1), so an impulse of the most negative input returns −2^(DATA_W−1)·c(k) for each tap.
- R9: Samples presented on consecutive cycles give results on consecutive cycles, one per sample and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | DATA_W | Two's-complement input sample |
| out_valid_o | output | 1 | Result strobe |
| out_data_o | output | ACC_W | Two's-complement filtered result |

## Verification
A unit impulse followed by zeros reads the weights back one at a time in tap order. This shows whether each table entry and each tap position, including the partly filled last group, is wired to the right weight. An impulse of the most negative input, followed by long runs of all-minimum and all-maximum samples, singles out the sign-slice subtraction and the width of the sums. Random samples with random idle gaps, and with garbage on the data bus while idle, separate a history that advances only on valid samples from one that advances on every cycle. Gap-free random streams check full throughput and the ordering of results.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  function automatic int da_acc_w(int data_w, int coef_w, int taps);
    return data_w + coef_w + $clog2(taps);
  endfunction

  function automatic int da_groups(int taps, int grp);
    return (taps + grp - 1) / grp;
  endfunction

endpackage

// File: rtl/dafir_delay.sv
module dafir_delay #(
  parameter int DATA_W   = 8,
  parameter int NUM_TAPS = 10
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             shift_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]  line_o
);

  logic [NUM_TAPS-1:0][DATA_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (shift_i) begin
      line_q[0] <= data_i;
      for (int k = 1; k < NUM_TAPS; k++) line_q[k] <= line_q[k-1];
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/dafir_group.sv
module dafir_group #(
  parameter int                          DATA_W     = 8,
  parameter int                          COEF_W     = 8,
  parameter int                          NUM_TAPS   = 10,
  parameter int                          GROUP_TAPS = 4,
  parameter int                          GROUP_BASE = 0,
  parameter int                          ACC_W      = 20,
  parameter logic [NUM_TAPS*COEF_W-1:0]  COEFS      = '0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               load_i,
  input  logic [GROUP_TAPS-1:0][DATA_W-1:0]  taps_i,
  output logic signed [ACC_W-1:0]            part_o
);

  localparam int ROM_W     = COEF_W + $clog2(GROUP_TAPS) + 1;
  localparam int ROM_DEPTH = 1 << GROUP_TAPS;

  // sum of the group weights selected by the set bits of addr
  function automatic logic signed [ROM_W-1:0] rom_entry(int addr);
    logic signed [ROM_W-1:0]  s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int t = 0; t < GROUP_TAPS; t++) begin
      if ((((addr >> t) & 1) == 1) && (GROUP_BASE + t < NUM_TAPS)) begin
        c = COEFS[(GROUP_BASE+t)*COEF_W +: COEF_W];
        s = s + ROM_W'(c);
      end
    end
    return s;
  endfunction

  logic signed [ROM_W-1:0] rom [ROM_DEPTH];

  for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_rom
    assign rom[a] = rom_entry(a);
  end

  logic [GROUP_TAPS-1:0]   addr;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] sum_d;
  logic signed [ACC_W-1:0] part_q;

  always_comb begin
    sum_d = '0;
    addr  = '0;
    term  = '0;
    for (int b = 0; b < DATA_W; b++) begin
      for (int t = 0; t < GROUP_TAPS; t++) addr[t] = taps_i[t][b];
      term = ACC_W'(rom[addr]) <<< b;
      // sign slice carries negative weight
      if (b == DATA_W - 1) sum_d = sum_d - term;
      else                 sum_d = sum_d + term;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     part_q <= '0;
    else if (load_i) part_q <= sum_d;
  end

  assign part_o = part_q;

endmodule

// File: rtl/dafir_adder.sv
module dafir_adder #(
  parameter int NUM_GROUPS = 3,
  parameter int ACC_W      = 20
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [NUM_GROUPS-1:0][ACC_W-1:0]  parts_i,
  output logic [ACC_W-1:0]                  sum_o
);

  logic [ACC_W-1:0] sum_d;
  logic [ACC_W-1:0] sum_q;

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < NUM_GROUPS; g++) sum_d = sum_d + parts_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (load_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/dafir_filter.sv
module dafir_filter #(
  parameter int                         DATA_W     = 8,
  parameter int                         COEF_W     = 8,
  parameter int                         NUM_TAPS   = 10,
  parameter int                         GROUP_TAPS = 4,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS      = {8'hCE, 8'h64, 8'h01, 8'hB3, 8'h00,
                                                      8'h19, 8'hFD, 8'h40, 8'h80, 8'h7F},
  localparam int ACC_W = dafir_pkg::da_acc_w(DATA_W, COEF_W, NUM_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [ACC_W-1:0]  out_data_o
);

  localparam int NUM_GROUPS = dafir_pkg::da_groups(NUM_TAPS, GROUP_TAPS);

  logic                                          shift_q;
  logic                                          grp_q;
  logic                                          out_q;
  logic [NUM_TAPS-1:0][DATA_W-1:0]               line;
  logic [NUM_GROUPS-1:0][GROUP_TAPS-1:0][DATA_W-1:0] grp_taps;
  logic [NUM_GROUPS-1:0][ACC_W-1:0]              parts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= 1'b0;
      grp_q   <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      shift_q <= in_valid_i;
      grp_q   <= shift_q;
      out_q   <= grp_q;
    end
  end

  dafir_delay #(
    .DATA_W  (DATA_W),
    .NUM_TAPS(NUM_TAPS)
  ) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(in_valid_i),
    .data_i (in_data_i),
    .line_o (line)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar t = 0; t < GROUP_TAPS; t++) begin : g_tap
      if (g * GROUP_TAPS + t < NUM_TAPS) begin : g_real
        assign grp_taps[g][t] = line[g*GROUP_TAPS+t];
      end else begin : g_pad
        assign grp_taps[g][t] = '0;
      end
    end

    dafir_group #(
      .DATA_W    (DATA_W),
      .COEF_W    (COEF_W),
      .NUM_TAPS  (NUM_TAPS),
      .GROUP_TAPS(GROUP_TAPS),
      .GROUP_BASE(g * GROUP_TAPS),
      .ACC_W     (ACC_W),
      .COEFS     (COEFS)
    ) u_group (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(shift_q),
      .taps_i(grp_taps[g]),
      .part_o(parts[g])
    );
  end

  dafir_adder #(
    .NUM_GROUPS(NUM_GROUPS),
    .ACC_W     (ACC_W)
  ) u_adder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (grp_q),
    .parts_i(parts),
    .sum_o  (out_data_o)
  );

  assign out_valid_o = out_q;

endmodule

// File: rtl/dafir_checker.sv
module dafir_checker #(
  parameter int                         DATA_W   = 8,
  parameter int                         COEF_W   = 8,
  parameter int                         NUM_TAPS = 10,
  parameter int                         ACC_W    = 20,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS    = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [ACC_W-1:0]  out_data_o
);

  function automatic longint max_mag();
    longint s;
    logic signed [COEF_W-1:0] c;
    s = 0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      c = COEFS[k*COEF_W +: COEF_W];
      s = s + ((c < 0) ? -longint'(c) : longint'(c)) * (longint'(1) << (DATA_W - 1));
    end
    return s;
  endfunction

  localparam longint BOUND = max_mag();

  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0) |-> (!out_valid_o && out_data_o == '0));

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !out_valid_o) |-> $stable(out_data_o));

  p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (longint'($signed(out_data_o)) <= BOUND &&
                     longint'($signed(out_data_o)) >= -BOUND));

endmodule

bind dafir_filter dafir_checker #(
  .DATA_W  (DATA_W),
  .COEF_W  (COEF_W),
  .NUM_TAPS(NUM_TAPS),
  .ACC_W   (ACC_W),
  .COEFS   (COEFS)
) u_dafir_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/dafir_filter_bench.sv
module dafir_filter_bench;

  localparam int DATA_W = 8;
  localparam int TAPS   = 10;
  localparam int OUT_W  = 20;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              out_valid;
  logic [OUT_W-1:0]  out_data;

  int total = 0;
  int bad   = 0;

  int     coef_tb [TAPS] = '{127, -128, 64, -3, 25, 0, -77, 1, 100, -50};
  longint hist [TAPS];
  bit     pv [3];
  longint pd [3];
  longint exp_last = 0;
  string  cur_req = "R3";

  dafir_filter u_dafir_filter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic longint model_push(longint x);
    longint s;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(coef_tb[k]) * hist[k];
    return s;
  endfunction

  task automatic check_val(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // check outputs for the sample driven three steps earlier, then drive new input
  task automatic step(bit v, logic [DATA_W-1:0] d);
    longint act;
    @(negedge clk);
    act = longint'($signed(out_data));
    check_val("R2", longint'(out_valid), longint'(pv[2]));
    if (pv[2]) begin
      check_val(cur_req, act, pd[2]);
      exp_last = pd[2];
    end else begin
      check_val("R5", act, exp_last);
    end
    pv[2] = pv[1]; pd[2] = pd[1];
    pv[1] = pv[0]; pd[1] = pd[0];
    pv[0] = v;
    pd[0] = v ? model_push(longint'($signed(d))) : 0;
    in_valid = v;
    in_data  = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    for (int k = 0; k < 3; k++) begin pv[k] = 0; pd[k] = 0; end
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check_val("R1", longint'(out_valid), 0);
    check_val("R1", longint'($signed(out_data)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1", longint'(out_valid), 0);
    check_val("R1", longint'($signed(out_data)), 0);

    // impulse reads back every weight, including last partial group
    cur_req = "R7";
    step(1'b1, 8'd1);
    for (int i = 0; i < TAPS + 2; i++) step(1'b1, 8'd0);

    // sign-slice weighting
    cur_req = "R8";
    step(1'b1, 8'h80);
    for (int i = 0; i < TAPS + 2; i++) step(1'b1, 8'd0);

    // extremes
    cur_req = "R6";
    for (int i = 0; i < TAPS + 3; i++) step(1'b1, 8'h80);
    for (int i = 0; i < TAPS + 3; i++) step(1'b1, 8'h7F);
    for (int i = 0; i < TAPS + 3; i++) step(1'b1, (i % 2 == 0) ? 8'h80 : 8'h7F);

    // idle gaps with garbage on the data bus
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(1, 0) == 1) step(1'b1, 8'($urandom));
      else                           step(1'b0, 8'($urandom));
    end

    // back-to-back
    cur_req = "R9";
    for (int i = 0; i < 300; i++) step(1'b1, 8'($urandom));

    // general random with occasional pauses
    cur_req = "R3";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(3, 0) != 0) step(1'b1, 8'($urandom));
      else                           step(1'b0, 8'($urandom));
    end

    for (int i = 0; i < 6; i++) step(1'b0, 8'($urandom));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule